// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a two-wire serial slave that lets a host reach a pair of 8-bit control registers feeding a clock output-control block. It samples SCL and SDA on a fast system clock and finds START and STOP conditions on the synchronized lines. It shifts in a 7-bit device address and a direction bit, and answers on SDA through an active-low open-drain enable. The block is always a slave and never stretches SCL.

A write carries a register address byte and then one or more data bytes. A read returns the register under an internal pointer. After each byte transferred, the pointer steps forward under a wrap rule that keeps its upper nibble at all ones. Once the low nibble is all ones, the next pointer value is 0xFE, not 0xF0. Random reads use a dummy write followed by a repeated START. A sequential read continues for as long as the host acknowledges.

Each accepted data byte also appears for one cycle on a write strobe, together with its address. The strobe is valid-only with no ready: the block cannot be back-pressured, so the consumer must take the byte in the cycle it is shown. Strobes are at least one SCL period apart.

Top module: `twi_regfile_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) begins a new transfer from any state, including a repeated START. A STOP (SDA rising while SCL is high) returns the slave to idle. A transfer cut off by STOP before its data byte writes nothing.
- R2: The slave acknowledges the address byte 0xAC (write) and 0xAD (read), i.e. the 7-bit address 1010110 with the direction bit in bit 0, where 1 means read. Any other address is not acknowledged. Later bytes in that transfer are not acknowledged and have no effect.
- R3: A write made of one address byte and one data byte updates the addressed register. The register outputs change only in the cycle of a write strobe.
- R4: In a multi-byte write the pointer advances after each data byte. Its upper four bits are forced to 1111, and the value after 0xFF is 0xFE. An address byte 0x0E therefore selects 0xFE.
- R5: A read with no address phase returns the register at the previous pointer value plus one, under the wrap rule of R4.
- R6: A random read (address write, repeated START, 0xAD) returns the register at the given address, MSB first.
- R7: In a read, a host ACK (SDA low in the ninth clock) makes the slave send the next register. A host NOACK ends the slave's driving.
- R8: The slave changes its SDA drive only while SCL is low.
- R9: Register 0xFF resets to 0x0C. Bit 7 is the full power-down request, bits 3:2 the 2-bit select of outputs 3 and 4, bit 1 the output 2 select and bit 0 the output 1 select.
- R10: Register 0xFE resets to 0x00. Bits 7..3 disable output 4, output 3, output 2, output 1 and the reference output; the `out_dis` port carries them in that order from bit 4 down to bit 0.
- R11: Writes to unused bits (0xFF bits 6:4, 0xFE bits 2:0) are ignored, and those bits read back as 0. Other addresses read 0 and ignore writes.
- R12: Each acknowledged data byte raises `wr_stb` for exactly one cycle, with the raw byte and the address written. The strobe comes at the SCL rising edge of that byte's ACK clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| pwr_down | output | 1 | Full power-down request (0xFF bit 7) |
| clk3_sel | output | 2 | Output 3/4 frequency select (0xFF bits 3:2) |
| clk2_sel | output | 1 | Output 2 frequency select (0xFF bit 1) |
| clk1_sel | output | 1 | Output 1 frequency select (0xFF bit 0) |
| out_dis | output | 5 | Disables {out4,out3,out2,out1,ref} (0xFE bits 7:3) |
| wr_stb | output | 1 | One-cycle strobe per written data byte |
| wr_addr | output | 8 | Register address of the strobed byte |
| wr_data | output | 8 | Raw data byte of the strobe |

## Verification
The bound checker watches several properties on every cycle. It checks that SDA drive holds steady while the synchronized SCL stays high. It checks that strobes last one cycle and always carry an address with a 1111 upper nibble. It also checks that the register outputs follow a strobe to 0xFE or 0xFF at once and never move without one. Some behaviour only host transactions can show, so the bench drives them. These cover address matching and ACK/NOACK, the 0xFF-to-0xFE wrap in page writes and in current-address reads, and sequential reads that stop on NOACK. They also cover unused bits reading back 0, and a STOP before the data byte leaving everything unchanged.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;
  localparam int LOW_W    = 4;
  localparam int HIGH_W   = ADDR_W - LOW_W;
  localparam int NREG     = 2;
  localparam int CNT_W    = $clog2(DATA_W + 1);

  localparam logic [HIGH_W-1:0] ADDR_HIGH = {HIGH_W{1'b1}};
  localparam logic [ADDR_W-1:0] PTR_RST   = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] PTR_WRAP  = {ADDR_W{1'b1}} - 1'b1;

  // index 1: power/select register, index 0: disable register
  localparam logic [NREG-1:0][ADDR_W-1:0] REG_ADDR = {8'hFF, 8'hFE};
  localparam logic [NREG-1:0][DATA_W-1:0] REG_MASK = {8'h8F, 8'hF8};
  localparam logic [NREG-1:0][DATA_W-1:0] REG_RST  = {8'h0C, 8'h00};

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_REG, ST_REG_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_MACK
  } twi_state_t;

  function automatic logic [ADDR_W-1:0] ptr_next(input logic [ADDR_W-1:0] a);
    if (a[LOW_W-1:0] == {LOW_W{1'b1}}) return PTR_WRAP;
    return {ADDR_HIGH, a[LOW_W-1:0] + 1'b1};
  endfunction
endpackage

// File: rtl/twi_sync_edge.sv
module twi_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_chain, sda_chain;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_in};
      sda_chain <= {sda_chain[STAGES-2:0], sda_in};
      scl_d     <= scl_chain[STAGES-1];
      sda_d     <= sda_chain[STAGES-1];
    end
  end

  assign scl_s     = scl_chain[STAGES-1];
  assign sda_s     = sda_chain[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_engine.sv
module twi_engine
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1010110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              addr_set,
  output logic              wr_req,
  output logic              rd_take,
  output logic [DATA_W-1:0] byte_out
);
  twi_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg, tx;
  logic              is_read, host_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      tx       <= '0;
      is_read  <= 1'b0;
      host_ack <= 1'b0;
      addr_set <= 1'b0;
      wr_req   <= 1'b0;
      rd_take  <= 1'b0;
    end else begin
      addr_set <= 1'b0;
      wr_req   <= 1'b0;
      rd_take  <= 1'b0;
      if (start_evt) begin
        state <= ST_DEV;
        cnt   <= '0;
      end else if (stop_evt) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_DEV, ST_REG, ST_WDAT: begin
            if (scl_rise) begin
              shreg <= {shreg[DATA_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_W'(DATA_W)) begin
              cnt <= '0;
              if (state == ST_DEV) begin
                if (shreg[DATA_W-1:1] == DEV_ADDR) begin
                  state   <= ST_DEV_ACK;
                  is_read <= shreg[0];
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_REG) begin
                state    <= ST_REG_ACK;
                addr_set <= 1'b1;
              end else begin
                state <= ST_WDAT_ACK;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              if (is_read) begin
                rd_take <= 1'b1;
                tx      <= rd_data;
                state   <= ST_RDAT;
              end else begin
                state <= ST_REG;
              end
            end
          end
          ST_REG_ACK:  if (scl_fall) state <= ST_WDAT;
          ST_WDAT_ACK: begin
            if (scl_rise) wr_req <= 1'b1;
            if (scl_fall) state  <= ST_WDAT;
          end
          ST_RDAT: begin
            if (scl_fall) begin
              tx <= {tx[DATA_W-2:0], 1'b0};
              if (cnt == CNT_W'(DATA_W - 1)) begin
                cnt   <= '0;
                state <= ST_MACK;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) host_ack <= ~sda_s;
            if (scl_fall) begin
              if (host_ack) begin
                rd_take <= 1'b1;
                tx      <= rd_data;
                state   <= ST_RDAT;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign byte_out = shreg;
  assign sda_oe   = (state == ST_DEV_ACK) || (state == ST_REG_ACK) ||
                    (state == ST_WDAT_ACK) || (state == ST_RDAT && !tx[DATA_W-1]);
endmodule

// File: rtl/twi_regbank.sv
module twi_regbank
  import twi_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        addr_set,
  input  logic                        wr_req,
  input  logic                        rd_take,
  input  logic [DATA_W-1:0]           byte_in,
  output logic [DATA_W-1:0]           rd_data,
  output logic [NREG-1:0][DATA_W-1:0] regs_q,
  output logic                        wr_stb,
  output logic [ADDR_W-1:0]           wr_addr,
  output logic [DATA_W-1:0]           wr_data
);
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= PTR_RST;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (addr_set) begin
        ptr <= {ADDR_HIGH, byte_in[LOW_W-1:0]};
      end else if (wr_req) begin
        ptr     <= ptr_next(ptr);
        wr_stb  <= 1'b1;
        wr_addr <= ptr;
        wr_data <= byte_in;
      end else if (rd_take) begin
        ptr <= ptr_next(ptr);
      end
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           regs_q[i] <= REG_RST[i];
      else if (wr_req && ptr == REG_ADDR[i]) regs_q[i] <= byte_in & REG_MASK[i];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (ptr == REG_ADDR[i]) rd_data = rd_data | regs_q[i];
  end
endmodule

// File: rtl/twi_regfile_slave.sv
module twi_regfile_slave
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1010110,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_oe,
  output logic        pwr_down,
  output logic [1:0]  clk3_sel,
  output logic        clk2_sel,
  output logic        clk1_sel,
  output logic [4:0]  out_dis,
  output logic        wr_stb,
  output logic [7:0]  wr_addr,
  output logic [7:0]  wr_data
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic addr_set, wr_req, rd_take;
  logic [DATA_W-1:0] byte_bus, rd_data;
  logic [NREG-1:0][DATA_W-1:0] regs_q;

  twi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  twi_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s),
    .rd_data(rd_data), .sda_oe(sda_oe), .addr_set(addr_set),
    .wr_req(wr_req), .rd_take(rd_take), .byte_out(byte_bus)
  );

  twi_regbank u_bank (
    .clk(clk), .rst_n(rst_n), .addr_set(addr_set), .wr_req(wr_req),
    .rd_take(rd_take), .byte_in(byte_bus), .rd_data(rd_data),
    .regs_q(regs_q), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign pwr_down = regs_q[1][7];
  assign clk3_sel = regs_q[1][3:2];
  assign clk2_sel = regs_q[1][1];
  assign clk1_sel = regs_q[1][0];
  assign out_dis  = regs_q[0][7:3];
endmodule

// File: rtl/twi_regfile_checker.sv
module twi_regfile_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       wr_stb,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       pwr_down,
  input logic [1:0] clk3_sel,
  input logic       clk2_sel,
  input logic       clk1_sel,
  input logic [4:0] out_dis
);
  logic [9:0] outs;
  assign outs = {pwr_down, clk3_sel, clk2_sel, clk1_sel, out_dis};

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R12
  AST_STB_HIGH_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> wr_addr[7:4] == 4'hF); // R4
  AST_SDA_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe)); // R8
  AST_FF_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == 8'hFF) |->
      {pwr_down, clk3_sel, clk2_sel, clk1_sel} == {wr_data[7], wr_data[3:0]}); // R9
  AST_FE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == 8'hFE) |-> out_dis == wr_data[7:3]); // R10
  AST_OUTS_NEED_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(outs) |-> wr_stb); // R3
endmodule

bind twi_regfile_slave twi_regfile_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
  .pwr_down(pwr_down), .clk3_sel(clk3_sel), .clk2_sel(clk2_sel),
  .clk1_sel(clk1_sel), .out_dis(out_dis)
);

// File: tb/tb_twi_regfile_slave.sv
module tb_twi_regfile_slave;
  localparam int Q  = 10;
  localparam int WD = 150000;
  localparam int NV = 8;
  // {address, write data, expected readback}
  localparam logic [NV-1:0][23:0] VEC = {
    24'h0E_55_50, 24'hFE_A8_A8, 24'hF3_AA_00, 24'hFF_0C_0C,
    24'hFE_07_00, 24'hFE_FF_F8, 24'hFF_70_00, 24'hFF_FF_8F
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, pwr_down, clk2_sel, clk1_sel, wr_stb;
  logic [1:0] clk3_sel;
  logic [4:0] out_dis;
  logic [7:0] wr_addr, wr_data;
  logic sda_bus;
  int checks = 0, failures = 0, stb_cnt = 0, hold_viol = 0;
  logic [7:0] last_addr = '0, last_data = '0;
  logic prev_scl = 1'b1, prev_oe = 1'b0, done = 1'b0;

  always #5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  twi_regfile_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .sda_oe(sda_oe), .pwr_down(pwr_down), .clk3_sel(clk3_sel),
    .clk2_sel(clk2_sel), .clk1_sel(clk1_sel), .out_dis(out_dis),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        stb_cnt++;
        last_addr = wr_addr;
        last_data = wr_data;
      end
      if (m_scl && prev_scl && sda_oe != prev_oe) hold_viol++;
    end
    prev_scl = m_scl;
    prev_oe  = sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic s);
    w(3); m_sda = b; w(Q); m_scl = 1'b1; w(Q); s = sda_bus; m_scl = 1'b0;
  endtask

  task automatic do_start();
    w(3); m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b0; w(Q); m_scl = 1'b0;
  endtask

  task automatic do_stop();
    w(3); m_sda = 1'b0; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b1; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
    bit_xfer(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      b[i] = s;
    end
    bit_xfer(~give_ack, s);
  endtask

  task automatic wr_one(input logic [7:0] a, input logic [7:0] d, output logic ok);
    logic k0, k1, k2;
    do_start(); send_byte(8'hAC, k0); send_byte(a, k1); send_byte(d, k2); do_stop();
    ok = k0 & k1 & k2;
  endtask

  task automatic rd_rand(input logic [7:0] a, output logic [7:0] d, output logic ok);
    logic k0, k1, k2;
    do_start(); send_byte(8'hAC, k0); send_byte(a, k1);
    do_start(); send_byte(8'hAD, k2); recv_byte(1'b0, d); do_stop();
    ok = k0 & k1 & k2;
  endtask

  task automatic rd_cur(output logic [7:0] d, output logic ok);
    do_start(); send_byte(8'hAD, ok); recv_byte(1'b0, d); do_stop();
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ok, k0, k1, k2, k3;
    logic [7:0] d, d1, d2;
    int s0;
    w(5); rst_n = 1'b1; w(5);
    // R9 R10 reset state
    chk("R9 reset ff", {pwr_down, 3'b000, clk3_sel, clk2_sel, clk1_sel}, 8'h0C);
    chk("R10 reset fe", out_dis, 0);
    chk("R8 idle release", sda_oe, 0);

    // R3 R11 R4 vector table: byte write, then random read of same address
    for (int v = 0; v < NV; v++) begin
      wr_one(VEC[v][23:16], VEC[v][15:8], ok);
      chk("R2 ack write", ok, 1);
      rd_rand(VEC[v][23:16], d, ok);
      chk("R2 ack read", ok, 1);
      chk("R3 R11 R6 readback", d, VEC[v][7:0]);
    end

    // R4 page write starting at 0xFE: FE<-A8, FF<-81, wrap FE<-33
    s0 = stb_cnt;
    do_start(); send_byte(8'hAC, k0); send_byte(8'hFE, k1);
    send_byte(8'hA8, k2); send_byte(8'h81, k3); send_byte(8'h33, ok); do_stop();
    chk("R4 page acks", {k0, k1, k2, k3, ok}, 5'b11111);
    chk("R4 wrap fe", out_dis, 5'b00110);
    chk("R4 ff", {pwr_down, clk3_sel, clk2_sel, clk1_sel}, 5'b1_00_0_1);
    chk("R12 strobe count", stb_cnt - s0, 3);
    chk("R12 strobe addr", last_addr, 8'hFE);
    chk("R12 strobe data", last_data, 8'h33);

    // R5 current address reads: pointer after wrap is FF, then FE
    rd_cur(d, ok);
    chk("R5 cur first", {ok, d}, {1'b1, 8'h81});
    rd_cur(d, ok);
    chk("R5 cur wrap", {ok, d}, {1'b1, 8'h30});

    // R7 sequential read from FE: FE, FF, FE
    do_start(); send_byte(8'hAC, k0); send_byte(8'hFE, k1);
    do_start(); send_byte(8'hAD, k2);
    recv_byte(1'b1, d); recv_byte(1'b1, d1); recv_byte(1'b0, d2);
    w(3);
    chk("R7 released after noack", sda_oe, 0);
    do_stop();
    chk("R7 seq bytes", {d, d1, d2}, {8'h30, 8'h81, 8'h30});

    // R2 address mismatch: no ack and later byte ignored
    s0 = stb_cnt;
    do_start(); send_byte(8'hA4, k0); send_byte(8'hFF, k1); send_byte(8'h00, k2); do_stop();
    chk("R2 mismatch nack", {k0, k1, k2}, 3'b000);
    chk("R2 no write", {pwr_down, clk1_sel, stb_cnt - s0}, {1'b1, 1'b1, 32'd0});

    // R1 STOP before data writes nothing
    do_start(); send_byte(8'hAC, k0); send_byte(8'hFF, k1); do_stop();
    chk("R1 abort no strobe", stb_cnt - s0, 0);
    rd_rand(8'hFF, d, ok);
    chk("R1 abort value kept", d, 8'h81);

    chk("R8 hold violations", hold_viol, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule